// File: doc/BRIEF.md
# Packet-Driven Configuration Register Bridge

This block sits behind a display-link receiver that has already turned lane traffic into bytes. It reads the packets carrying configuration accesses and turns them into transfers on a simple internal register bus. A generic long write carries a register address and one or more data words. Each word after the first goes to the next register. A two-parameter generic read carries its address in the header and produces a four-byte response stream, which the receiver's return path sends back to the host.

The input is a byte stream. A start flag marks the first of four header bytes, and an end flag marks the last byte of the packet. The header bytes arrive in this order: data byte 1 (also the low word-count byte), data byte 2 (the high word-count byte), the identifier byte and the error-code byte. Taken together, little-endian, they form a 32-bit header word: the data type sits in bits 21:16, the channel number in bits 23:22, and the two data bytes in bits 15:0. The error-code byte is not examined. Only packets on the configured channel are acted on.

While a read is outstanding, or while its response is being sent, the input is not watched. The host is expected to wait for the response before it sends again.

Top module: `pkb_bridge`

## Requirements
- R1: A packet whose channel field (identifier byte bits 7:6) differs from `cfg_vc` produces no bus transfer and no response.
- R2: A packet whose data type (identifier byte bits 5:0) is neither 0x29 nor 0x24 produces no bus transfer and no response.
- R3: In a write (type 0x29), the first two payload bytes form the register address, low byte first. Each following group of four bytes forms one 32-bit word, least significant byte first, so the low 16-bit half comes before the high half. Each word raises `bus_wr_en` for exactly one cycle, with the address and word on `bus_addr` and `bus_wdata`.
- R4: Each further word in the same write packet goes to the previous address plus `ADDR_STEP` (default 4).
- R5: A read (type 0x24) to any address other than the identification address raises `bus_rd_req` for one cycle. During that cycle `bus_addr` holds data byte 2 as the high byte and data byte 1 as the low byte.
- R6: A read response is four bytes on `rsp_byte`, least significant first, with `rsp_valid` high and `rsp_last` high on the fourth byte. `rsp_valid` stays low until `bus_rd_valid` has been seen.
- R7: A read of address 0x0580 answers 0x00006500 without any bus request.
- R8: If a write ends with one to three bytes of an incomplete word, those bytes are discarded with no bus transfer, and `err_leftover` goes high and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_vc | input | 2 | Channel number this bridge answers |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Byte is the first header byte |
| in_eop | input | 1 | Byte is the last byte of the packet |
| in_byte | input | 8 | Input byte |
| bus_wr_en | output | 1 | One-cycle write strobe |
| bus_rd_req | output | 1 | One-cycle read request |
| bus_addr | output | 16 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rd_valid | input | 1 | Read data valid |
| bus_rd_data | input | 32 | Read data |
| rsp_valid | output | 1 | Response byte valid |
| rsp_byte | output | 8 | Response byte |
| rsp_last | output | 1 | Final response byte |
| err_leftover | output | 1 | Sticky flag for a partial trailing word |

## Verification
The hardest case to reach from the ports is a response held back by a slow register bus. The bench's bus model delays `bus_rd_valid` by a programmable number of cycles. At the moment it raises valid, it records how many response bytes have already appeared, and that count must still be zero. A second hard case is the partial trailing word. The bench sends a complete word followed by two stray bytes. It then confirms that exactly one write happened and that the error flag rose. After a later clean write, it confirms the flag is still set.

// File: rtl/pkb_pkg.sv
package pkb_pkg;
   localparam int HDR_BYTES = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_ADDR,
      ST_DATA,
      ST_DROP,
      ST_RDWAIT
   } rx_state_e;
endpackage

// File: rtl/pkb_rx.sv
module pkb_rx
   import pkb_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 32,
   parameter int          ADDR_STEP = 4,
   parameter logic [5:0]  DT_WRITE  = 6'h29,
   parameter logic [5:0]  DT_READ   = 6'h24,
   parameter bit          ID_EN     = 1'b1,
   parameter logic [15:0] ID_ADDR   = 16'h0580,
   parameter logic [31:0] ID_VALUE  = 32'h0000_6500
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_vc,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic [7:0]        in_byte,
   input  logic              rsp_busy,
   output logic              bus_wr_en,
   output logic              bus_rd_req,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd_valid,
   input  logic [DATA_W-1:0] bus_rd_data,
   output logic              rsp_load,
   output logic [DATA_W-1:0] rsp_word,
   output logic              err_leftover
);
   localparam int WB = DATA_W / 8;
   localparam int AB = ADDR_W / 8;
   localparam int CW = (WB > AB) ? $clog2(WB) : $clog2(AB);
   localparam int HW = $clog2(HDR_BYTES);

   rx_state_e         state;
   logic [HW-1:0]     hcnt;
   logic [CW-1:0]     bcnt;
   logic [23:0]       hbuf;
   logic [ADDR_W-1:0] waddr;
   logic [DATA_W-1:0] wbuf;

   logic              hdr_done, vc_ok, is_wr, is_rd, id_hit;
   logic [1:0]        hvc;
   logic [5:0]        hdt;
   logic [ADDR_W-1:0] haddr;

   assign hvc      = hbuf[23:22];
   assign hdt      = hbuf[21:16];
   assign haddr    = hbuf[ADDR_W-1:0];
   assign hdr_done = (state == ST_HDR) && in_valid && (hcnt == HW'(HDR_BYTES - 1));
   assign vc_ok    = (hvc == cfg_vc);
   assign is_wr    = vc_ok && (hdt == DT_WRITE);
   assign is_rd    = vc_ok && (hdt == DT_READ);

   generate
      if (ID_EN) begin : g_id
         assign id_hit = (haddr == ID_ADDR[ADDR_W-1:0]);
      end else begin : g_no_id
         assign id_hit = 1'b0;
      end
   endgenerate

   assign rsp_load = (hdr_done && is_rd && id_hit) ||
                     ((state == ST_RDWAIT) && bus_rd_valid);
   assign rsp_word = (state == ST_RDWAIT) ? bus_rd_data : ID_VALUE[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         hcnt         <= '0;
         bcnt         <= '0;
         hbuf         <= '0;
         waddr        <= '0;
         wbuf         <= '0;
         bus_wr_en    <= 1'b0;
         bus_rd_req   <= 1'b0;
         bus_addr     <= '0;
         bus_wdata    <= '0;
         err_leftover <= 1'b0;
      end else begin
         bus_wr_en  <= 1'b0;
         bus_rd_req <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (in_valid && in_sop && !rsp_busy) begin
                  hbuf[7:0] <= in_byte;
                  hcnt      <= HW'(1);
                  state     <= in_eop ? ST_IDLE : ST_HDR;
               end
            end
            ST_HDR: begin
               if (in_valid) begin
                  if (hcnt != HW'(HDR_BYTES - 1)) begin
                     hbuf[hcnt*8 +: 8] <= in_byte;
                     hcnt              <= hcnt + HW'(1);
                     if (in_eop) state <= ST_IDLE;
                  end else if (is_wr) begin
                     bcnt  <= '0;
                     state <= in_eop ? ST_IDLE : ST_ADDR;
                  end else if (is_rd) begin
                     if (id_hit) begin
                        state <= in_eop ? ST_IDLE : ST_DROP;
                     end else begin
                        bus_rd_req <= 1'b1;
                        bus_addr   <= haddr;
                        state      <= ST_RDWAIT;
                     end
                  end else begin
                     state <= in_eop ? ST_IDLE : ST_DROP;
                  end
               end
            end
            ST_ADDR: begin
               if (in_valid) begin
                  waddr[bcnt*8 +: 8] <= in_byte;
                  if (bcnt == CW'(AB - 1)) begin
                     bcnt  <= '0;
                     state <= in_eop ? ST_IDLE : ST_DATA;
                  end else begin
                     bcnt <= bcnt + CW'(1);
                     if (in_eop) begin
                        err_leftover <= 1'b1;
                        state        <= ST_IDLE;
                     end
                  end
               end
            end
            ST_DATA: begin
               if (in_valid) begin
                  wbuf[bcnt*8 +: 8] <= in_byte;
                  if (bcnt == CW'(WB - 1)) begin
                     bcnt      <= '0;
                     bus_wr_en <= 1'b1;
                     bus_addr  <= waddr;
                     bus_wdata <= {in_byte, wbuf[DATA_W-9:0]};
                     waddr     <= waddr + ADDR_W'(ADDR_STEP);
                     if (in_eop) state <= ST_IDLE;
                  end else begin
                     bcnt <= bcnt + CW'(1);
                     if (in_eop) begin
                        err_leftover <= 1'b1;
                        state        <= ST_IDLE;
                     end
                  end
               end
            end
            ST_DROP: begin
               if (in_valid && in_eop) state <= ST_IDLE;
            end
            ST_RDWAIT: begin
               if (bus_rd_valid) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pkb_tx.sv
module pkb_tx #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] word,
   output logic              rsp_valid,
   output logic [7:0]        rsp_byte,
   output logic              rsp_last,
   output logic              busy
);
   localparam int WB = DATA_W / 8;
   localparam int IW = (WB > 1) ? $clog2(WB) : 1;

   logic [DATA_W-1:0] shreg;
   logic [IW-1:0]     idx;
   logic              active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         idx    <= '0;
         active <= 1'b0;
      end else if (load) begin
         shreg  <= word;
         idx    <= '0;
         active <= 1'b1;
      end else if (active) begin
         shreg <= shreg >> 8;
         idx   <= idx + IW'(1);
         if (idx == IW'(WB - 1)) active <= 1'b0;
      end
   end

   assign rsp_valid = active;
   assign rsp_byte  = shreg[7:0];
   assign rsp_last  = active && (idx == IW'(WB - 1));
   assign busy      = active;
endmodule

// File: rtl/pkb_bridge.sv
module pkb_bridge #(
   parameter int          ADDR_W    = 16,
   parameter int          DATA_W    = 32,
   parameter int          ADDR_STEP = 4,
   parameter logic [5:0]  DT_WRITE  = 6'h29,
   parameter logic [5:0]  DT_READ   = 6'h24,
   parameter bit          ID_EN     = 1'b1,
   parameter logic [15:0] ID_ADDR   = 16'h0580,
   parameter logic [31:0] ID_VALUE  = 32'h0000_6500
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_vc,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic              in_eop,
   input  logic [7:0]        in_byte,
   output logic              bus_wr_en,
   output logic              bus_rd_req,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd_valid,
   input  logic [DATA_W-1:0] bus_rd_data,
   output logic              rsp_valid,
   output logic [7:0]        rsp_byte,
   output logic              rsp_last,
   output logic              err_leftover
);
   generate
      if (ADDR_W != 16) begin : g_bad_addr_w
         $error("pkb_bridge: ADDR_W must be 16, the header address width");
      end
      if ((DATA_W % 8) != 0 || DATA_W < 16 || DATA_W > 64) begin : g_bad_data_w
         $error("pkb_bridge: DATA_W must be a whole number of bytes in 16..64");
      end
      if (ADDR_STEP < 1) begin : g_bad_step
         $error("pkb_bridge: ADDR_STEP must be positive");
      end
   endgenerate

   logic              rsp_load, rsp_busy;
   logic [DATA_W-1:0] rsp_word;

   pkb_rx #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ADDR_STEP(ADDR_STEP),
      .DT_WRITE(DT_WRITE), .DT_READ(DT_READ),
      .ID_EN(ID_EN), .ID_ADDR(ID_ADDR), .ID_VALUE(ID_VALUE)
   ) rx_i (
      .clk(clk), .rst_n(rst_n), .cfg_vc(cfg_vc),
      .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_byte(in_byte),
      .rsp_busy(rsp_busy),
      .bus_wr_en(bus_wr_en), .bus_rd_req(bus_rd_req),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rd_valid(bus_rd_valid), .bus_rd_data(bus_rd_data),
      .rsp_load(rsp_load), .rsp_word(rsp_word),
      .err_leftover(err_leftover)
   );

   pkb_tx #(.DATA_W(DATA_W)) tx_i (
      .clk(clk), .rst_n(rst_n), .load(rsp_load), .word(rsp_word),
      .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .rsp_last(rsp_last),
      .busy(rsp_busy)
   );
endmodule

// File: rtl/pkb_bridge_chk.sv
module pkb_bridge_chk #(
   parameter int DATA_W = 32
) (
   input logic clk,
   input logic rst_n,
   input logic bus_wr_en,
   input logic bus_rd_req,
   input logic rsp_valid,
   input logic rsp_last,
   input logic err_leftover
);
   localparam int WB = DATA_W / 8;
   int unsigned rsp_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsp_cnt <= 0;
      else if (rsp_valid) rsp_cnt <= rsp_last ? 0 : rsp_cnt + 1;
   end

   // R3: write strobe lasts one cycle
   a_r3_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr_en |=> !bus_wr_en);
   // R5: read request lasts one cycle
   a_r5_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_req |=> !bus_rd_req);
   // R6: last flag only on a valid byte
   a_r6_last_valid: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_last |-> rsp_valid);
   // R6: last flag marks the final byte of a word
   a_r6_rsp_len: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_cnt == WB - 1) |-> rsp_last);
   // R8: error flag is sticky
   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_leftover |=> err_leftover);
   // R5 R3: read request and write strobe never coincide
   a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr_en && bus_rd_req));
endmodule

bind pkb_bridge pkb_bridge_chk #(.DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_req(bus_rd_req),
   .rsp_valid(rsp_valid), .rsp_last(rsp_last), .err_leftover(err_leftover)
);

// File: tb/pkb_bridge_tb_top.sv
module pkb_bridge_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_vc = 2'd1;
   logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        bus_wr_en, bus_rd_req, rsp_valid, rsp_last, err_leftover;
   logic [15:0] bus_addr;
   logic [31:0] bus_wdata;
   logic        bus_rd_valid = 1'b0;
   logic [31:0] bus_rd_data = 32'h0;
   logic [7:0]  rsp_byte;

   always #2 clk = ~clk;

   pkb_bridge dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_vc(cfg_vc),
      .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_byte(in_byte),
      .bus_wr_en(bus_wr_en), .bus_rd_req(bus_rd_req),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rd_valid(bus_rd_valid), .bus_rd_data(bus_rd_data),
      .rsp_valid(rsp_valid), .rsp_byte(rsp_byte), .rsp_last(rsp_last),
      .err_leftover(err_leftover)
   );

   int n_chk = 0, n_fail = 0;

   // observation state
   logic [15:0] wr_addr [0:15];
   logic [31:0] wr_data [0:15];
   int          wr_n, rdreq_n, rsp_n, last_pos, rsp_before_valid, lat;
   logic [15:0] rd_addr_seen;
   logic [7:0]  rsp_b [0:15];
   logic [7:0]  pl [0:31];

   // bus model and monitors, all on the falling edge
   bit          rd_pend = 0;
   int          lat_cnt = 0;
   always @(negedge clk) begin
      bus_rd_valid = 1'b0;
      if (rd_pend) begin
         if (lat_cnt == 0) begin
            bus_rd_valid     = 1'b1;
            bus_rd_data      = {rd_addr_seen, ~rd_addr_seen};
            rsp_before_valid = rsp_n;
            rd_pend          = 0;
         end else lat_cnt--;
      end
      if (bus_rd_req) begin
         rd_pend      = 1;
         lat_cnt      = lat;
         rd_addr_seen = bus_addr;
         rdreq_n++;
      end
      if (bus_wr_en && wr_n < 16) begin
         wr_addr[wr_n] = bus_addr;
         wr_data[wr_n] = bus_wdata;
         wr_n++;
      end
      if (rsp_valid && rsp_n < 16) begin
         rsp_b[rsp_n] = rsp_byte;
         if (rsp_last) last_pos = rsp_n;
         rsp_n++;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic clear_obs();
      wr_n = 0; rdreq_n = 0; rsp_n = 0; last_pos = -1; rsp_before_valid = -1; lat = 0;
   endtask

   task automatic put(input logic [7:0] b, input logic s, input logic e);
      @(negedge clk);
      in_valid = 1'b1; in_byte = b; in_sop = s; in_eop = e;
   endtask

   task automatic send_pkt(input logic [5:0] dt, input logic [1:0] vc,
                           input logic [7:0] d1, input logic [7:0] d2, input int n);
      put(d1, 1'b1, 1'b0);
      put(d2, 1'b0, 1'b0);
      put({vc, dt}, 1'b0, 1'b0);
      put(8'h00, 1'b0, n == 0);
      for (int i = 0; i < n; i++) put(pl[i], 1'b0, i == n - 1);
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      repeat (lat + 12) @(negedge clk);
   endtask

   function automatic logic [31:0] rsp_word();
      return {rsp_b[3], rsp_b[2], rsp_b[1], rsp_b[0]};
   endfunction

   task automatic t_reset();
      @(negedge clk);
      chk(bus_wr_en == 0, "R3 reset wr_en", 32'(bus_wr_en), 0);
      chk(bus_rd_req == 0, "R5 reset rd_req", 32'(bus_rd_req), 0);
      chk(rsp_valid == 0, "R6 reset rsp_valid", 32'(rsp_valid), 0);
      chk(err_leftover == 0, "R8 reset err", 32'(err_leftover), 0);
   endtask

   task automatic t_single_write();
      clear_obs();
      pl[0] = 8'h54; pl[1] = 8'h04;
      pl[2] = 8'h44; pl[3] = 8'h33; pl[4] = 8'h22; pl[5] = 8'h11;
      send_pkt(6'h29, 2'd1, 8'h06, 8'h00, 6);
      chk(wr_n == 1, "R3 write count", 32'(wr_n), 1);
      chk(wr_addr[0] == 16'h0454, "R3 write addr", 32'(wr_addr[0]), 32'h0454);
      chk(wr_data[0] == 32'h11223344, "R3 write data", wr_data[0], 32'h11223344);
   endtask

   task automatic t_multi_write();
      clear_obs();
      pl[0] = 8'h80; pl[1] = 8'h04;
      for (int w = 0; w < 3; w++)
         for (int b = 0; b < 4; b++) pl[2 + w*4 + b] = 8'(16*w + b + 1);
      send_pkt(6'h29, 2'd1, 8'h0E, 8'h00, 14);
      chk(wr_n == 3, "R4 burst count", 32'(wr_n), 3);
      for (int w = 0; w < 3; w++) begin
         logic [31:0] e;
         e = {8'(16*w + 4), 8'(16*w + 3), 8'(16*w + 2), 8'(16*w + 1)};
         chk(wr_addr[w] == 16'h0480 + 16'(4*w), "R4 burst addr",
             32'(wr_addr[w]), 32'h0480 + 32'(4*w));
         chk(wr_data[w] == e, "R4 burst data", wr_data[w], e);
      end
   endtask

   task automatic t_read(input int latency);
      clear_obs();
      lat = latency;
      send_pkt(6'h24, 2'd1, 8'h04, 8'h01, 0);
      chk(rdreq_n == 1, "R5 read request count", 32'(rdreq_n), 1);
      chk(rd_addr_seen == 16'h0104, "R5 read addr", 32'(rd_addr_seen), 32'h0104);
      chk(rsp_before_valid == 0, "R6 idle until valid", 32'(rsp_before_valid), 0);
      chk(rsp_n == 4, "R6 response length", 32'(rsp_n), 4);
      chk(rsp_word() == {16'h0104, 16'hFEFB}, "R6 response value", rsp_word(),
          {16'h0104, 16'hFEFB});
      chk(last_pos == 3, "R6 last flag position", 32'(last_pos), 3);
   endtask

   task automatic t_id_read();
      clear_obs();
      send_pkt(6'h24, 2'd1, 8'h80, 8'h05, 0);
      chk(rdreq_n == 0, "R7 no bus request", 32'(rdreq_n), 0);
      chk(rsp_n == 4, "R7 response length", 32'(rsp_n), 4);
      chk(rsp_word() == 32'h00006500, "R7 id value", rsp_word(), 32'h00006500);
   endtask

   task automatic t_filtered();
      clear_obs();
      pl[0] = 8'h54; pl[1] = 8'h04;
      pl[2] = 8'h01; pl[3] = 8'h02; pl[4] = 8'h03; pl[5] = 8'h04;
      send_pkt(6'h29, 2'd2, 8'h06, 8'h00, 6);
      send_pkt(6'h24, 2'd0, 8'h04, 8'h01, 0);
      chk(wr_n == 0, "R1 other channel write", 32'(wr_n), 0);
      chk(rdreq_n == 0 && rsp_n == 0, "R1 other channel read", 32'(rdreq_n + rsp_n), 0);
      clear_obs();
      send_pkt(6'h05, 2'd1, 8'h06, 8'h00, 6);
      send_pkt(6'h14, 2'd1, 8'h04, 8'h01, 0);
      chk(wr_n == 0, "R2 unknown type write", 32'(wr_n), 0);
      chk(rdreq_n == 0 && rsp_n == 0, "R2 unknown type read", 32'(rdreq_n + rsp_n), 0);
   endtask

   task automatic t_leftover();
      clear_obs();
      pl[0] = 8'h24; pl[1] = 8'h05;
      pl[2] = 8'hAA; pl[3] = 8'hBB; pl[4] = 8'hCC; pl[5] = 8'hDD;
      pl[6] = 8'h77; pl[7] = 8'h66;
      send_pkt(6'h29, 2'd1, 8'h08, 8'h00, 8);
      chk(wr_n == 1, "R8 only complete word written", 32'(wr_n), 1);
      chk(wr_data[0] == 32'hDDCCBBAA, "R8 complete word data", wr_data[0], 32'hDDCCBBAA);
      chk(err_leftover == 1, "R8 error raised", 32'(err_leftover), 1);
      clear_obs();
      pl[0] = 8'h24; pl[1] = 8'h05;
      send_pkt(6'h29, 2'd1, 8'h06, 8'h00, 6);
      chk(wr_n == 1, "R8 later write ok", 32'(wr_n), 1);
      chk(err_leftover == 1, "R8 error sticky", 32'(err_leftover), 1);
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      clear_obs();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_single_write();
      t_multi_write();
      t_read(0);
      t_read(9);
      t_id_read();
      t_filtered();
      t_leftover();
      summary();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 1, 0);
      summary();
   end
endmodule